// File: doc/BRIEF.md
# Link Packet Receive Parser

This block sits behind the byte-capture stage of a point-to-point chip link. Each clock it receives one byte and a frame level. A rising frame marks the first byte of a transaction. The block tracks the position of every following byte and fills the header and payload fields. When the last byte of a transaction arrives, it presents a 104-bit transaction word together with a one-cycle strobe.

While frame stays high after a transaction ends, the far end continues in burst form. Only the eight payload bytes of each further transaction are sent. The block reuses the header it already holds and steps the destination address by eight for every new transaction.

Two pushback outputs tell the far end to pause. One serves read requests and the other serves writes. Each follows its own downstream ready input, and the far end may still complete one more transaction after a wait goes high. If frame drops before a transaction is complete, the partial transaction is thrown away.

Top module: `link_rx_parser`

## Requirements
- R1: While reset is applied and in the cycle after it is released, `pkt_valid_o`, `wr_wait_o` and `rd_wait_o` are low and `pkt_o` is all zeros.
- R2: A transaction starts only when `frame_i` is sampled high at an edge after being sampled low at the previous edge. The byte sampled at that edge is byte 0, and its contents have no effect on `pkt_o`.
- R3: Header bytes map as follows. Byte 1 is {ctrl[3:0], dst[31:28]}. Bytes 2, 3 and 4 are dst[27:20], dst[19:12] and dst[11:4]. Byte 5 is {dst[3:0], mode[1:0], wr, valid-flag}, and the valid-flag bit is not stored.
- R4: Bytes 6 to 9 are data[31:24] down to data[7:0]. Bytes 10 to 13 are src[31:24] down to src[7:0]. `pkt_valid_o` is high in the cycle after the edge that samples byte 13.
- R5: `pkt_o` holds wr at [0], mode at [2:1], ctrl at [6:3], zero at [7], dst at [39:8], data at [71:40] and src at [103:72]. It keeps this value unchanged until the next strobe.
- R6: If `frame_i` is still high at the edge after byte 13, that byte is byte 6 of a new transaction. The new transaction reuses ctrl, mode and wr, and its dst is the previous dst plus 8.
- R7: If `frame_i` is sampled low before byte 13 of a transaction has been taken, no strobe is produced for that transaction. The next transaction decodes normally.
- R8: `pkt_valid_o` is high for exactly one cycle per completed transaction.
- R9: `wr_wait_o` is high in the cycle after `wr_ready_i` is sampled low, and low in the cycle after it is sampled high.
- R10: `rd_wait_o` follows `rd_ready_i` in the same way and is independent of `wr_ready_i`.
- R11: A frame that is already high when reset is released starts no transaction. Frame must first be sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link-side clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_i | input | 1 | Frame level from the far end |
| byte_i | input | 8 | Received byte for this cycle |
| wr_ready_i | input | 1 | Downstream can take more writes |
| rd_ready_i | input | 1 | Downstream can take more read requests |
| pkt_valid_o | output | 1 | One-cycle strobe for a completed transaction |
| pkt_o | output | 104 | Assembled transaction word |
| wr_wait_o | output | 1 | Pushback toward the far end for writes |
| rd_wait_o | output | 1 | Pushback toward the far end for reads |

## Verification
Byte k of a transaction is sampled at the k-th rising edge after the frame edge. The strobe and the new transaction word appear one register later, after the edge that samples byte 13. A wait output moves one edge after its ready input changes. An aborted transaction must leave the strobe low from the edge where the drop is seen onward. The bench drives every input on the falling edge and reads outputs on the next falling edge, so each result is read exactly one register stage after the edge that produces it. Strobe counts are taken a few cycles after each scenario so that a stray pulse is caught.

// File: rtl/lrx_pkg.sv
package lrx_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int CTRL_W     = 4;
  localparam int MODE_W     = 2;
  localparam int IDX_W      = 4;
  localparam int PKT_W      = 3 * ADDR_W + 1 + CTRL_W + MODE_W + 1;
  localparam int DATA_FIRST = 6;
  localparam int PKT_LAST   = 13;
  localparam int BURST_STEP = 8;

  typedef logic [IDX_W-1:0] idx_t;

  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [DATA_W-1:0] data;
    logic [ADDR_W-1:0] dst;
    logic              rsvd;
    logic [CTRL_W-1:0] ctrl;
    logic [MODE_W-1:0] mode;
    logic              wr;
  } pkt_t;

  // Address of the following transaction inside a burst.
  function automatic logic [ADDR_W-1:0] burst_next(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(BURST_STEP);
  endfunction

  function automatic pkt_t pack_pkt(input logic [CTRL_W-1:0] ctrl,
                                    input logic [MODE_W-1:0] mode,
                                    input logic              wr,
                                    input logic [ADDR_W-1:0] dst,
                                    input logic [DATA_W-1:0] data,
                                    input logic [ADDR_W-1:0] src);
    pkt_t p;
    p.src  = src;
    p.data = data;
    p.dst  = dst;
    p.rsvd = 1'b0;
    p.ctrl = ctrl;
    p.mode = mode;
    p.wr   = wr;
    return p;
  endfunction
endpackage

// File: rtl/lrx_frame_track.sv
module lrx_frame_track
  import lrx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_i,
  output logic start_o,
  output logic take_o,
  output logic done_o,
  output logic abort_o,
  output idx_t idx_o
);
  logic frame_q, active_q, burst_q;
  idx_t idx_q;

  always_comb begin
    start_o = frame_i & ~frame_q;
    take_o  = active_q & frame_i;
    done_o  = take_o & (idx_q == idx_t'(PKT_LAST));
    // A drop right after a finished transaction is a clean end, not an abort.
    abort_o = active_q & ~frame_i & ~(burst_q & (idx_q == idx_t'(DATA_FIRST)));
  end

  assign idx_o = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q  <= 1'b1;
      active_q <= 1'b0;
      burst_q  <= 1'b0;
      idx_q    <= '0;
    end else begin
      frame_q <= frame_i;
      if (start_o) begin
        active_q <= 1'b1;
        burst_q  <= 1'b0;
        idx_q    <= idx_t'(1);
      end else if (take_o) begin
        if (done_o) begin
          idx_q   <= idx_t'(DATA_FIRST);
          burst_q <= 1'b1;
        end else begin
          idx_q <= idx_q + idx_t'(1);
        end
      end else if (active_q) begin
        active_q <= 1'b0;
        burst_q  <= 1'b0;
      end
    end
  end

  AST_START_TO_BYTE1: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> (active_q && idx_q == idx_t'(1))); // R2
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (idx_q >= idx_t'(1) && idx_q <= idx_t'(PKT_LAST))); // R4
  AST_BURST_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (idx_q == idx_t'(DATA_FIRST))); // R6
endmodule

// File: rtl/lrx_field_capture.sv
module lrx_field_capture
  import lrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              done_i,
  input  idx_t              idx_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              pkt_valid_o,
  output pkt_t              pkt_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [MODE_W-1:0] mode_q;
  logic              wr_q;
  logic [ADDR_W-1:0] dst_q;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:BYTE_W] src_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      mode_q      <= '0;
      wr_q        <= 1'b0;
      dst_q       <= '0;
      data_q      <= '0;
      src_q       <= '0;
      pkt_valid_o <= 1'b0;
      pkt_o       <= '0;
    end else begin
      pkt_valid_o <= done_i;
      if (take_i) begin
        case (int'(idx_i))
          1:  begin ctrl_q <= byte_i[7:4]; dst_q[31:28] <= byte_i[3:0]; end
          2:  dst_q[27:20] <= byte_i;
          3:  dst_q[19:12] <= byte_i;
          4:  dst_q[11:4]  <= byte_i;
          5:  begin
                dst_q[3:0] <= byte_i[7:4];
                mode_q     <= byte_i[3:2];
                wr_q       <= byte_i[1];
              end
          6:  data_q[31:24] <= byte_i;
          7:  data_q[23:16] <= byte_i;
          8:  data_q[15:8]  <= byte_i;
          9:  data_q[7:0]   <= byte_i;
          10: src_q[31:24]  <= byte_i;
          11: src_q[23:16]  <= byte_i;
          12: src_q[15:8]   <= byte_i;
          default: ;
        endcase
      end
      if (done_i) begin
        pkt_o <= pack_pkt(ctrl_q, mode_q, wr_q, dst_q, data_q, {src_q, byte_i});
        dst_q <= burst_next(dst_q);
      end
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid_o |=> !pkt_valid_o); // R8
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid_o |-> $stable(pkt_o)); // R5
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid_o |-> (pkt_o.rsvd == 1'b0)); // R5
endmodule

// File: rtl/lrx_wait_gen.sv
module lrx_wait_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic ready_i,
  output logic wait_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) wait_o <= 1'b0;
    else        wait_o <= ~ready_i;
  end
endmodule

// File: rtl/link_rx_parser.sv
module link_rx_parser
  import lrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              wr_ready_i,
  input  logic              rd_ready_i,
  output logic              pkt_valid_o,
  output logic [PKT_W-1:0]  pkt_o,
  output logic              wr_wait_o,
  output logic              rd_wait_o
);
  localparam int N_CHAN = 2;

  logic start_ev, take_ev, done_ev, abort_ev;
  idx_t idx_s;
  pkt_t pkt_s;
  logic [N_CHAN-1:0] ready_v, wait_v;

  lrx_frame_track u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame_i (frame_i),
    .start_o (start_ev),
    .take_o  (take_ev),
    .done_o  (done_ev),
    .abort_o (abort_ev),
    .idx_o   (idx_s)
  );

  lrx_field_capture u_fields (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_i      (take_ev),
    .done_i      (done_ev),
    .idx_i       (idx_s),
    .byte_i      (byte_i),
    .pkt_valid_o (pkt_valid_o),
    .pkt_o       (pkt_s)
  );

  assign pkt_o   = pkt_s;
  assign ready_v = {rd_ready_i, wr_ready_i};

  // Channel 0 pushes back writes, channel 1 pushes back read requests.
  for (genvar c = 0; c < N_CHAN; c++) begin : g_wait
    lrx_wait_gen u_wait (
      .clk     (clk),
      .rst_n   (rst_n),
      .ready_i (ready_v[c]),
      .wait_o  (wait_v[c])
    );
  end

  assign wr_wait_o = wait_v[0];
  assign rd_wait_o = wait_v[1];

  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> !pkt_valid_o); // R7
  AST_NO_START_MIDWAY: assert property (@(posedge clk) disable iff (!rst_n)
    take_ev |-> !start_ev); // R2
  AST_WR_WAIT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready_i |=> wr_wait_o); // R9
  AST_WR_WAIT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready_i |=> !wr_wait_o); // R9
  AST_RD_WAIT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ready_i |=> rd_wait_o); // R10
  AST_RD_WAIT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready_i |=> !rd_wait_o); // R10
endmodule

// File: tb/link_rx_parser_test.sv
`timescale 1ns/1ps
module link_rx_parser_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         frame_i = 1'b1;
  logic [7:0]   byte_i = 8'h00;
  logic         wr_ready_i = 1'b1;
  logic         rd_ready_i = 1'b1;
  logic         pkt_valid_o;
  logic [103:0] pkt_o;
  logic         wr_wait_o;
  logic         rd_wait_o;

  int tests = 0;
  int fails = 0;
  int strobes = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  link_rx_parser uut (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .byte_i(byte_i),
    .wr_ready_i(wr_ready_i), .rd_ready_i(rd_ready_i),
    .pkt_valid_o(pkt_valid_o), .pkt_o(pkt_o),
    .wr_wait_o(wr_wait_o), .rd_wait_o(rd_wait_o)
  );

  always @(posedge clk) if (pkt_valid_o) strobes++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      tests++; fails++;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<=20000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [103:0] act, input logic [103:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Set inputs, then move to the next falling edge (one rising edge passes).
  task automatic put(input logic f, input logic [7:0] b);
    frame_i = f; byte_i = b;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(1'b0, 8'h00);
  endtask

  task automatic send_hdr(input logic [3:0] ctrl, input logic [31:0] dst,
                          input logic [1:0] mode, input logic wr);
    put(1'b1, 8'hA5); // byte 0, content must not matter (R2)
    put(1'b1, {ctrl, dst[31:28]});
    put(1'b1, dst[27:20]);
    put(1'b1, dst[19:12]);
    put(1'b1, dst[11:4]);
    put(1'b1, {dst[3:0], mode, wr, 1'b1});
  endtask

  task automatic send_body(input logic [31:0] data, input logic [31:0] src);
    for (int k = 3; k >= 0; k--) put(1'b1, data[8*k +: 8]);
    for (int k = 3; k >= 0; k--) put(1'b1, src[8*k +: 8]);
  endtask

  // Called at the falling edge after byte 13 was sampled.
  task automatic expect_pkt(input string name, input logic [3:0] ctrl, input logic [1:0] mode,
                            input logic wr, input logic [31:0] dst,
                            input logic [31:0] data, input logic [31:0] src);
    logic [103:0] e;
    e = '0;
    e[103:72] = src; e[71:40] = data; e[39:8] = dst;
    e[6:3] = ctrl; e[2:1] = mode; e[0] = wr;
    chk({name, " R4 strobe after byte 13"}, {103'd0, pkt_valid_o}, 104'd1);
    chk({name, " R3 dst"}, {72'd0, pkt_o[39:8]}, {72'd0, dst});
    chk({name, " R3 ctrl/mode/wr"}, {97'd0, pkt_o[6:0]}, {97'd0, ctrl, mode, wr});
    chk({name, " R4 data/src"}, {40'd0, pkt_o[103:40]}, {40'd0, src, data});
    chk({name, " R5 packed word"}, pkt_o, e);
  endtask

  task automatic t_reset_and_held_frame;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {103'd0, pkt_valid_o}, '0);
    chk("R1 waits in reset", {102'd0, wr_wait_o, rd_wait_o}, '0);
    rst_n = 1'b1;
    chk("R1 word after reset", pkt_o, '0);
    // Frame was high through reset: stays high with bytes, nothing may start (R11).
    for (int i = 0; i < 20; i++) put(1'b1, 8'(i * 7));
    idle(2);
    chk("R11 held frame gives no strobe", 104'(strobes), 104'd0);
  endtask

  task automatic t_single_write;
    int s0;
    s0 = strobes;
    send_hdr(4'h5, 32'h8080_0004, 2'b10, 1'b1);
    send_body(32'hDEAD_BEEF, 32'hAAAA_5555);
    expect_pkt("write", 4'h5, 2'b10, 1'b1, 32'h8080_0004, 32'hDEAD_BEEF, 32'hAAAA_5555);
    put(1'b0, 8'h00);
    chk("R8 strobe low next cycle", {103'd0, pkt_valid_o}, '0);
    idle(3);
    chk("R8 one strobe per write", 104'(strobes - s0), 104'd1);
  endtask

  task automatic t_single_read;
    send_hdr(4'h0, 32'h1234_5678, 2'b11, 1'b0);
    send_body(32'h0F1E_2D3C, 32'h810D_0010);
    expect_pkt("read", 4'h0, 2'b11, 1'b0, 32'h1234_5678, 32'h0F1E_2D3C, 32'h810D_0010);
    idle(3);
  endtask

  task automatic t_burst;
    int s0;
    s0 = strobes;
    send_hdr(4'hC, 32'h4000_0FF8, 2'b11, 1'b1);
    send_body(32'h1111_1111, 32'hA0A0_A0A0);
    expect_pkt("burst0", 4'hC, 2'b11, 1'b1, 32'h4000_0FF8, 32'h1111_1111, 32'hA0A0_A0A0);
    send_body(32'h2222_2222, 32'hB1B1_B1B1);
    expect_pkt("burst1 R6", 4'hC, 2'b11, 1'b1, 32'h4000_1000, 32'h2222_2222, 32'hB1B1_B1B1);
    send_body(32'h3333_3333, 32'hC2C2_C2C2);
    expect_pkt("burst2 R6", 4'hC, 2'b11, 1'b1, 32'h4000_1008, 32'h3333_3333, 32'hC2C2_C2C2);
    idle(6);
    chk("R8 three strobes in burst", 104'(strobes - s0), 104'd3);
    chk("R5 word held after burst", pkt_o[39:8], 104'h4000_1008);
  endtask

  task automatic t_abort;
    int s0;
    s0 = strobes;
    send_hdr(4'h3, 32'hCAFE_0000, 2'b01, 1'b1);
    put(1'b1, 8'h99); put(1'b1, 8'h88); put(1'b1, 8'h77);
    idle(4);
    chk("R7 drop mid data no strobe", 104'(strobes - s0), 104'd0);
    send_hdr(4'h3, 32'hCAFE_0000, 2'b01, 1'b1);
    idle(4);
    chk("R7 drop after header no strobe", 104'(strobes - s0), 104'd0);
    chk("R7 word kept after aborts", pkt_o[39:8], 104'h4000_1008);
    send_hdr(4'h9, 32'h0000_0100, 2'b00, 1'b0);
    send_body(32'h5A5A_5A5A, 32'h0BAD_F00D);
    expect_pkt("after abort R7", 4'h9, 2'b00, 1'b0, 32'h0000_0100, 32'h5A5A_5A5A, 32'h0BAD_F00D);
    idle(3);
  endtask

  task automatic t_wait;
    wr_ready_i = 1'b0; put(1'b0, 8'h00);
    chk("R9 wr wait rises", {103'd0, wr_wait_o}, 104'd1);
    chk("R10 rd wait unaffected", {103'd0, rd_wait_o}, '0);
    // A transaction still completes while pushback is shown.
    send_hdr(4'h1, 32'h0000_0040, 2'b10, 1'b1);
    send_body(32'h7777_8888, 32'h0);
    expect_pkt("under wait R9", 4'h1, 2'b10, 1'b1, 32'h0000_0040, 32'h7777_8888, 32'h0);
    wr_ready_i = 1'b1; rd_ready_i = 1'b0; put(1'b0, 8'h00);
    chk("R9 wr wait falls", {103'd0, wr_wait_o}, '0);
    chk("R10 rd wait rises", {103'd0, rd_wait_o}, 104'd1);
    rd_ready_i = 1'b1; put(1'b0, 8'h00);
    chk("R10 rd wait falls", {103'd0, rd_wait_o}, '0);
  endtask

  initial begin
    t_reset_and_held_frame();
    t_single_write();
    t_single_read();
    t_burst();
    t_abort();
    t_wait();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule